// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

This block turns one eight-lane media-independent word per enabled cycle into a 66-bit line block: a 64-bit payload and a 2-bit sync header. Each word carries 64 data bits and one control flag per byte lane. The encoder sorts the word by its lane pattern into one of the standard block kinds and builds the payload for that kind. The kinds are: all data, all control, frame start in lane 0 or lane 4, ordered sets in lane 0, lane 4 or both, and frame end in any of the eight lanes.

After encoding, three line-side stages may be applied. The first is a self-synchronous scrambler on the payload. The second is a bit-slip rotation that moves the 66-bit block boundary by one bit per slip pulse, to train a receiver's block lock. The third is a mirror of the bit order for serialisers that send the most significant bit first. A clock enable freezes the whole block, so one encoder can run below the clock rate.

Top module: `ebBlockEncoder`

## Requirements
- R1: When no control flag is set, the header is 2'b01 and the payload equals the input word, lane i in bits 8i+7..8i. The result is visible after the rising edge that captured the word.
- R2: When any control flag is set, the header is 2'b10. Each control character maps to a 7-bit code: 07h->00h, 06h->06h, FEh->1Eh, 1Ch->2Dh, 3Ch->33h, 7Ch->4Bh, BCh->55h, DCh->66h, F7h->78h, and any other byte ->1Eh. The code of lane i sits at payload bit 8+7i. A control word that matches no other kind is sent with type byte 1Eh.
- R3: Start character FBh in lane 0, with lanes 1-7 all data, gives type 78h and lanes 1-7 in payload bytes 1-7.
- R4: Start in lane 4, with lanes 5-7 as data, gives type 33h. This type carries the codes of lanes 0-3 from bit 8, bits 36-39 at zero, and lanes 5-7 in bytes 5-7. If lane 0 also holds an ordered set and lanes 1-3 are data, the type is 66h instead, with lanes 1-3 in bytes 1-3, the lane-0 O code in bits 32-35, and lanes 5-7 in bytes 5-7.
- R5: An ordered-set character is 9Ch (sequence, O code 0h) or 5Ch (signal, O code Fh). Lane 0 alone with data lanes 1-3 gives type 4Bh: lanes 1-3 in bytes 1-3, the O code in bits 32-35, and lane 4-7 codes from bit 36. Lane 4 alone with data lanes 5-7 gives type 2Dh: lane 0-3 codes from bit 8, the O code in bits 36-39, and lanes 5-7 in bytes 5-7. Both lanes together give type 55h, with lane 0's O code in bits 32-35 and lane 4's in bits 36-39.
- R6: Terminate FDh in lane k, with lanes below k all data, gives type 87h, 99h, AAh, B4h, CCh, D2h, E1h or FFh for k = 0..7. The data of lanes 0..k-1 moves to bytes 1..k. The codes of lanes above k stay at bit 8+7i.
- R7: With scrambling on, payload bits are processed from LSB up. Each one is XORed with state bits 38 and 57, and the result is shifted into the state (x^58+x^39+1). The header passes unscrambled.
- R8: Each enabled slip pulse advances a bit offset modulo 66. At a non-zero offset, the 66-bit output {payload, header} is taken from {current block, previous block} shifted right by 66 minus the offset.
- R9: With reversal on, the 64 payload bits and the 2 header bits are each mirrored on their own.
- R10: While the clock enable is low, the outputs, the slip offset and the scrambler hold, and slip pulses are ignored.
- R11: Reset clears both outputs and the slip offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clkEn | input | 1 | Advances the block when high |
| scrambleEn | input | 1 | Scramble the payload |
| reverseEn | input | 1 | Mirror payload and header bit order |
| slip | input | 1 | Advance the block boundary by one bit |
| txData | input | 64 | Lane bytes, lane 0 in bits 7..0 |
| txCtrl | input | 8 | Control flag per lane |
| blkData | output | 64 | Encoded payload |
| blkHdr | output | 2 | Sync header |

## Verification
Every result is due one enabled rising edge after its word is presented. The bench drives each word on a falling edge and compares at the next falling edge, after exactly one rising edge. The slip result depends on the block from the previous edge, so slip cases are checked in pairs of consecutive words. The scrambler check descrambles the second of two consecutive outputs using state rebuilt from the first, so that result is compared one edge after the second word.

// File: rtl/ebEncPkg.sv
package ebEncPkg;
  localparam int LANES  = 8;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int HDR_W  = 2;
  localparam int BLK_W  = DATA_W + HDR_W;
  localparam int CODE_W = 7;
  localparam int OCODE_W = 4;
  localparam int SCR_LEN = 58;
  localparam int SCR_TAP = 39;
  localparam int OFS_W  = $clog2(BLK_W);

  localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_SEQ   = 8'h9C;
  localparam logic [7:0] CH_SIG   = 8'h5C;

  localparam logic [7:0] TY_CTRL  = 8'h1E;
  localparam logic [7:0] TY_OS4   = 8'h2D;
  localparam logic [7:0] TY_S4    = 8'h33;
  localparam logic [7:0] TY_OSS4  = 8'h66;
  localparam logic [7:0] TY_OS04  = 8'h55;
  localparam logic [7:0] TY_S0    = 8'h78;
  localparam logic [7:0] TY_OS0   = 8'h4B;

  localparam logic [OCODE_W-1:0] O_SEQ = 4'h0;
  localparam logic [OCODE_W-1:0] O_SIG = 4'hF;

  typedef enum logic [3:0] {
    BLK_DATA, BLK_CTRL, BLK_S0, BLK_S4, BLK_OSS4,
    BLK_OS0, BLK_OS4, BLK_OS04, BLK_TERM
  } blkKind_e;

  typedef struct packed {
    blkKind_e         kind;
    logic [2:0]       termLane;
    logic             sig0;
    logic             sig4;
    logic [OFS_W-1:0] ofs;
  } encStrb_t;

  function automatic logic [CODE_W-1:0] mapCode(input logic [7:0] ch);
    case (ch)
      8'h07:   mapCode = 7'h00;
      8'h06:   mapCode = 7'h06;
      8'hFE:   mapCode = 7'h1E;
      8'h1C:   mapCode = 7'h2D;
      8'h3C:   mapCode = 7'h33;
      8'h7C:   mapCode = 7'h4B;
      8'hBC:   mapCode = 7'h55;
      8'hDC:   mapCode = 7'h66;
      8'hF7:   mapCode = 7'h78;
      default: mapCode = 7'h1E;
    endcase
  endfunction

  function automatic logic [7:0] termType(input logic [2:0] lane);
    case (lane)
      3'd0:    termType = 8'h87;
      3'd1:    termType = 8'h99;
      3'd2:    termType = 8'hAA;
      3'd3:    termType = 8'hB4;
      3'd4:    termType = 8'hCC;
      3'd5:    termType = 8'hD2;
      3'd6:    termType = 8'hE1;
      default: termType = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/ebEncCtrl.sv
module ebEncCtrl
  import ebEncPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              slip,
  input  logic [DATA_W-1:0] txData,
  input  logic [LANES-1:0]  txCtrl,
  output encStrb_t          strb,
  output logic [OFS_W-1:0]  slipOfs
);
  logic [7:0] ln [LANES];
  logic [LANES-1:0] isOs;
  logic [LANES-1:0] isSig;
  logic [LANES-1:0] termAt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ln[g]     = txData[BYTE_W*g +: BYTE_W];
    assign isOs[g]   = txCtrl[g] && (ln[g] == CH_SEQ || ln[g] == CH_SIG);
    assign isSig[g]  = ln[g] == CH_SIG;
    if (g == 0) begin : g_t0
      assign termAt[g] = txCtrl[g] && ln[g] == CH_TERM;
    end else begin : g_tn
      assign termAt[g] = txCtrl[g] && ln[g] == CH_TERM && txCtrl[g-1:0] == '0;
    end
  end

  logic       termHit;
  logic [2:0] termK;

  always_comb begin
    termHit = 1'b0;
    termK   = '0;
    for (int k = 0; k < LANES; k++) begin
      if (termAt[k]) begin
        termHit = 1'b1;
        termK   = 3'(k);
      end
    end
  end

  logic start0, start4, os0Ok, os4Ok;
  assign start0 = txCtrl[0] && ln[0] == CH_START && txCtrl[7:1] == '0;
  assign start4 = txCtrl[4] && ln[4] == CH_START && txCtrl[7:5] == '0;
  assign os0Ok  = isOs[0] && txCtrl[3:1] == '0;
  assign os4Ok  = isOs[4] && txCtrl[7:5] == '0;

  always_comb begin
    strb.termLane = termK;
    strb.sig0     = isSig[0];
    strb.sig4     = isSig[4];
    if (txCtrl == '0)     strb.kind = BLK_DATA;
    else if (start0)      strb.kind = BLK_S0;
    else if (start4)      strb.kind = os0Ok ? BLK_OSS4 : BLK_S4;
    else if (os0Ok)       strb.kind = os4Ok ? BLK_OS04 : BLK_OS0;
    else if (os4Ok)       strb.kind = BLK_OS4;
    else if (termHit)     strb.kind = BLK_TERM;
    else                  strb.kind = BLK_CTRL;
  end

  logic [OFS_W-1:0] ofsReg, ofsNow;
  assign ofsNow = !slip ? ofsReg
                : (ofsReg == OFS_W'(BLK_W - 1)) ? '0 : ofsReg + 1'b1;
  assign strb.ofs = ofsNow;
  assign slipOfs  = ofsReg;

  always_ff @(posedge clk) begin
    if (rst)        ofsReg <= '0;
    else if (clkEn) ofsReg <= ofsNow;
  end
endmodule

// File: rtl/ebEncPath.sv
module ebEncPath
  import ebEncPkg::*;
#(
  parameter logic [SCR_LEN-1:0] SCR_SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              scrambleEn,
  input  logic              reverseEn,
  input  logic [DATA_W-1:0] txData,
  input  encStrb_t          strb,
  output logic [DATA_W-1:0] blkData,
  output logic [HDR_W-1:0]  blkHdr
);
  logic [7:0]        ln    [LANES];
  logic [CODE_W-1:0] codes [LANES];
  logic [CODE_W*LANES-1:0] codeAll;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ln[g]    = txData[BYTE_W*g +: BYTE_W];
    assign codes[g] = mapCode(ln[g]);
    assign codeAll[CODE_W*g +: CODE_W] = codes[g];
  end

  logic [OCODE_W-1:0] oVal0, oVal4;
  assign oVal0 = strb.sig0 ? O_SIG : O_SEQ;
  assign oVal4 = strb.sig4 ? O_SIG : O_SEQ;

  logic [DATA_W-1:0] termPay;
  always_comb begin
    termPay = '0;
    termPay[7:0] = termType(strb.termLane);
    for (int i = 0; i < LANES - 1; i++)
      if (i < int'(strb.termLane)) termPay[BYTE_W*(i+1) +: BYTE_W] = ln[i];
    for (int i = 1; i < LANES; i++)
      if (i > int'(strb.termLane)) termPay[BYTE_W + CODE_W*i +: CODE_W] = codes[i];
  end

  logic [DATA_W-1:0] pay;
  logic [HDR_W-1:0]  hdr;
  always_comb begin
    hdr = HDR_CTRL;
    case (strb.kind)
      BLK_DATA: begin pay = txData; hdr = HDR_DATA; end
      BLK_S0:   pay = {txData[63:8], TY_S0};
      BLK_S4:   pay = {txData[63:40], 4'h0, codeAll[27:0], TY_S4};
      BLK_OSS4: pay = {txData[63:40], 4'h0, oVal0, txData[31:8], TY_OSS4};
      BLK_OS0:  pay = {codeAll[55:28], oVal0, txData[31:8], TY_OS0};
      BLK_OS4:  pay = {txData[63:40], oVal4, codeAll[27:0], TY_OS4};
      BLK_OS04: pay = {txData[63:40], oVal4, oVal0, txData[31:8], TY_OS04};
      BLK_TERM: pay = termPay;
      default:  pay = {codeAll, TY_CTRL};
    endcase
  end

  logic [SCR_LEN-1:0] scrState, scrNext;
  logic [DATA_W-1:0]  scrPay;
  always_comb begin
    logic [SCR_LEN-1:0] s;
    logic fb;
    s = scrState;
    for (int i = 0; i < DATA_W; i++) begin
      fb        = s[SCR_TAP-1] ^ s[SCR_LEN-1] ^ pay[i];
      scrPay[i] = fb;
      s         = {s[SCR_LEN-2:0], fb};
    end
    scrNext = s;
  end

  logic [BLK_W-1:0]   curBlk, lastBlk, slipBlk;
  logic [2*BLK_W-1:0] wide;
  assign curBlk = {scrambleEn ? scrPay : pay, hdr};
  assign wide   = {curBlk, lastBlk} >> (OFS_W'(BLK_W) - strb.ofs);
  assign slipBlk = (strb.ofs == '0) ? curBlk : wide[BLK_W-1:0];

  logic [DATA_W-1:0] outPay;
  logic [HDR_W-1:0]  outHdr;
  always_comb begin
    outPay = slipBlk[BLK_W-1:HDR_W];
    outHdr = slipBlk[HDR_W-1:0];
    if (reverseEn) begin
      for (int i = 0; i < DATA_W; i++) outPay[i] = slipBlk[HDR_W + DATA_W - 1 - i];
      for (int i = 0; i < HDR_W; i++)  outHdr[i] = slipBlk[HDR_W - 1 - i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scrState <= SCR_SEED;
      lastBlk  <= '0;
      blkData  <= '0;
      blkHdr   <= '0;
    end else if (clkEn) begin
      if (scrambleEn) scrState <= scrNext;
      lastBlk <= curBlk;
      blkData <= outPay;
      blkHdr  <= outHdr;
    end
  end
endmodule

// File: rtl/ebBlockEncoder.sv
module ebBlockEncoder
  import ebEncPkg::*;
#(
  parameter logic [SCR_LEN-1:0] SCR_SEED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic              scrambleEn,
  input  logic              reverseEn,
  input  logic              slip,
  input  logic [DATA_W-1:0] txData,
  input  logic [LANES-1:0]  txCtrl,
  output logic [DATA_W-1:0] blkData,
  output logic [HDR_W-1:0]  blkHdr
);
  encStrb_t         strb;
  logic [OFS_W-1:0] slipOfs;

  ebEncCtrl u_ctrl (
    .clk(clk), .rst(rst), .clkEn(clkEn), .slip(slip),
    .txData(txData), .txCtrl(txCtrl), .strb(strb), .slipOfs(slipOfs)
  );

  ebEncPath #(.SCR_SEED(SCR_SEED)) u_path (
    .clk(clk), .rst(rst), .clkEn(clkEn), .scrambleEn(scrambleEn),
    .reverseEn(reverseEn), .txData(txData), .strb(strb),
    .blkData(blkData), .blkHdr(blkHdr)
  );
endmodule

// File: rtl/ebBlockEncoderChk.sv
module ebBlockEncoderChk
  import ebEncPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              clkEn,
  input logic              scrambleEn,
  input logic              reverseEn,
  input logic              slip,
  input logic [DATA_W-1:0] txData,
  input logic [LANES-1:0]  txCtrl,
  input logic [DATA_W-1:0] blkData,
  input logic [HDR_W-1:0]  blkHdr,
  input logic [OFS_W-1:0]  slipOfs
);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> ($stable(blkData) && $stable(blkHdr)));

  // R10
  hold_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(slipOfs));

  // R1
  data_blk_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && txCtrl == '0 && !scrambleEn && !reverseEn && !slip && slipOfs == '0)
    |=> (blkHdr == HDR_DATA && blkData == $past(txData)));

  // R2
  ctrl_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && txCtrl != '0 && !reverseEn && !slip && slipOfs == '0)
    |=> blkHdr == HDR_CTRL);

  // R8
  ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
    slipOfs < OFS_W'(BLK_W));

  // R8
  ofs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && slip && slipOfs != OFS_W'(BLK_W - 1))
    |=> slipOfs == $past(slipOfs) + 1'b1);

  // R8
  ofs_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (clkEn && slip && slipOfs == OFS_W'(BLK_W - 1)) |=> slipOfs == '0);
endmodule

bind ebBlockEncoder ebBlockEncoderChk u_chk (
  .clk(clk), .rst(rst), .clkEn(clkEn), .scrambleEn(scrambleEn),
  .reverseEn(reverseEn), .slip(slip), .txData(txData), .txCtrl(txCtrl),
  .blkData(blkData), .blkHdr(blkHdr), .slipOfs(slipOfs)
);

// File: tb/tb_ebBlockEncoder.sv
module tb_ebBlockEncoder;
  localparam int NV = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, clkEn, scrambleEn, reverseEn, slip;
  logic [63:0] txData;
  logic [7:0]  txCtrl;
  logic [63:0] blkData;
  logic [1:0]  blkHdr;

  ebBlockEncoder dut (
    .clk(clk), .rst(rst), .clkEn(clkEn), .scrambleEn(scrambleEn),
    .reverseEn(reverseEn), .slip(slip), .txData(txData), .txCtrl(txCtrl),
    .blkData(blkData), .blkHdr(blkHdr)
  );

  localparam logic [63:0] VEC_D [NV] = '{
    64'h0807060504030201, 64'h0707070707070707, 64'hD5555555555555FB,
    64'h555555FB07070707, 64'h07070707070707FD, 64'h07070707FDCCBBAA,
    64'hFD77665544332211, 64'h070707070302019C, 64'h333231FB1312115C,
    64'h2322215C1312119C, 64'h2322215C07070707, 64'h07070707070707FE,
    64'h0707070707074207, 64'h070707071CFDBBAA, 64'h0607070707070707,
    64'h0707070707FB0707};
  localparam logic [7:0] VEC_C [NV] = '{
    8'h00, 8'hFF, 8'h01, 8'h1F, 8'hFF, 8'hF8, 8'h80, 8'hF1,
    8'h11, 8'h11, 8'h1F, 8'hFF, 8'hFF, 8'hFC, 8'hFF, 8'hFF};
  localparam logic [63:0] VEC_P [NV] = '{
    64'h0807060504030201, 64'h000000000000001E, 64'hD555555555555578,
    64'h5555550000000033, 64'h0000000000000087, 64'h00000000CCBBAAB4,
    64'h77665544332211FF, 64'h000000000302014B, 64'h3332310F13121166,
    64'h232221F013121155, 64'h232221F00000002D, 64'h0000000000001E1E,
    64'h00000000000F001E, 64'h00000005A0BBAAAA, 64'h0C0000000000001E,
    64'h000000000780001E};
  localparam logic [1:0] VEC_H [NV] = '{
    2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10};
  string vecReq [NV] = '{
    "R1", "R2", "R3", "R4", "R6", "R6", "R6", "R5",
    "R4", "R5", "R5", "R2", "R2", "R6", "R2", "R2"};

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] rev64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[63-i] = v[i];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [65:0] blkX, blkY, blkZ, got, exp66;
    logic [63:0] scrA, scrB, desc;
    logic [57:0] st;
    logic fb;

    rst = 1'b1; clkEn = 1'b0; scrambleEn = 1'b0; reverseEn = 1'b0; slip = 1'b0;
    txData = '0; txCtrl = '0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared by reset
    check({blkData, blkHdr} == 66'd0, "R11", {blkData, blkHdr}, 66'd0);
    rst = 1'b0;
    clkEn = 1'b1;

    for (int v = 0; v < NV; v++) begin
      txData = VEC_D[v];
      txCtrl = VEC_C[v];
      step();
      check({blkData, blkHdr} == {VEC_P[v], VEC_H[v]}, vecReq[v],
            {blkData, blkHdr}, {VEC_P[v], VEC_H[v]});
    end

    // R10: disabled cycle holds output and ignores slip
    clkEn = 1'b0; slip = 1'b1;
    txData = VEC_D[0]; txCtrl = VEC_C[0];
    step();
    check({blkData, blkHdr} == {VEC_P[15], VEC_H[15]}, "R10",
          {blkData, blkHdr}, {VEC_P[15], VEC_H[15]});
    clkEn = 1'b1; slip = 1'b0;
    txData = VEC_D[1]; txCtrl = VEC_C[1];
    step();
    check({blkData, blkHdr} == {VEC_P[1], VEC_H[1]}, "R10",
          {blkData, blkHdr}, {VEC_P[1], VEC_H[1]});

    // R9: reversal of payload and header
    reverseEn = 1'b1;
    txData = VEC_D[6]; txCtrl = VEC_C[6];
    step();
    exp66 = {rev64(VEC_P[6]), 2'b01};
    check({blkData, blkHdr} == exp66, "R9", {blkData, blkHdr}, exp66);
    reverseEn = 1'b0;

    // R8: slip by one bit, then wrap after 66 pulses
    blkX = {VEC_P[2], VEC_H[2]};
    blkY = {VEC_P[6], VEC_H[6]};
    blkZ = {VEC_P[3], VEC_H[3]};
    txData = VEC_D[2]; txCtrl = VEC_C[2];
    step();
    check({blkData, blkHdr} == blkX, "R8", {blkData, blkHdr}, blkX);
    txData = VEC_D[6]; txCtrl = VEC_C[6]; slip = 1'b1;
    step();
    exp66 = {blkY[64:0], blkX[65]};
    check({blkData, blkHdr} == exp66, "R8", {blkData, blkHdr}, exp66);
    txData = VEC_D[3]; txCtrl = VEC_C[3]; slip = 1'b0;
    step();
    exp66 = {blkZ[64:0], blkY[65]};
    check({blkData, blkHdr} == exp66, "R8", {blkData, blkHdr}, exp66);
    txData = VEC_D[0]; txCtrl = VEC_C[0]; slip = 1'b1;
    repeat (65) step();
    check({blkData, blkHdr} == {VEC_P[0], VEC_H[0]}, "R8",
          {blkData, blkHdr}, {VEC_P[0], VEC_H[0]});
    slip = 1'b0;
    step();
    check({blkData, blkHdr} == {VEC_P[0], VEC_H[0]}, "R8",
          {blkData, blkHdr}, {VEC_P[0], VEC_H[0]});

    // R7: scrambled stream descrambles back to the plain block
    scrambleEn = 1'b1;
    txData = VEC_D[2]; txCtrl = VEC_C[2];
    step();
    scrA = blkData;
    check(scrA != VEC_P[2], "R7", {scrA, blkHdr}, {VEC_P[2], VEC_H[2]});
    txData = VEC_D[6]; txCtrl = VEC_C[6];
    step();
    scrB = blkData;
    check(blkHdr == 2'b10, "R7", {64'd0, blkHdr}, {64'd0, 2'b10});
    for (int k = 0; k < 58; k++) st[k] = scrA[63-k];
    for (int i = 0; i < 64; i++) begin
      fb = scrB[i];
      desc[i] = fb ^ st[38] ^ st[57];
      st = {st[56:0], fb};
    end
    check(desc == VEC_P[6], "R7", {desc, 2'b10}, {VEC_P[6], 2'b10});
    scrambleEn = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule